// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block is the lowest layer of an I2C master. It turns one command at a time into correctly timed activity on the two open-drain bus lines: a start condition, a repeated start, a stop condition, a byte written with the target's acknowledge captured, or a byte read followed by an acknowledge or not-acknowledge clock that the master drives. A higher-level sequencer builds addresses and messages out of these primitives. It waits on `cmd_ready` and fires `cmd_valid` with an operation code. It then waits for the one-cycle `cmd_done` pulse and collects the read byte, the acknowledge result and the timeout flag.

Each line is only ever pulled low or let go. The pad logic outside turns `scl_pull` and `sda_pull` into an open-drain driver and returns the wire levels on `scl_in` and `sda_in`. Both returns pass through a two-stage synchroniser. Timing is based on a delay unit U, counted in system clock cycles. A low phase and a data setup take half a unit. A clock-high phase and the start and stop hold times take a full unit.

When SCL sensing is on, every release of SCL is followed by a wait until the synchronised SCL actually reads high. This is how a target can stretch the clock. If the wait exceeds a programmed number of cycles, the operation aborts with a sticky timeout flag. For pins that cannot read SCL back, sensing can be switched off. The high phase is then timed blindly.

The state machine has these states:
- `S_IDLE`: waits for a command.
- `S_ST_SDA` then `S_ST_SCL`: start condition.
- `S_RS_REL`, `S_RS_HIGH`, `S_RS_SDA`, `S_RS_SCL`: repeated start.
- `S_SP_SDA`, `S_SP_HIGH`, `S_SP_REL`: stop condition.
- `S_BIT_SET`, `S_BIT_HIGH`, `S_BIT_LOW`: the data bit loop, shared by write and read.
- `S_ACK_SET`, `S_ACK_HIGH`, `S_ACK_LOW`: the ninth clock.
- `S_DONE`: a one-cycle completion state that returns to `S_IDLE`.

Every timed state advances when its phase count ends. The four high states (`*_HIGH`) can instead jump to `S_DONE` on a stretch timeout. `S_BIT_LOW` goes back to `S_BIT_SET` until eight bits are done, and then goes to `S_ACK_SET`.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both lines are released (`scl_pull`=0, `sda_pull`=0), `cmd_ready`=1 and `err_timeout`=0.
- R2: Start (`cmd_op`=1) pulls SDA first and pulls SCL exactly U cycles later. It ends with both lines pulled low, and a monitor sees exactly one start condition.
- R3: Repeated start (`cmd_op`=2) releases SDA, lets SCL go high, pulls SDA while SCL is high and then pulls SCL. One start condition appears on the bus and both lines end pulled.
- R4: Stop (`cmd_op`=3) pulls SDA while SCL is low, releases SCL and then releases SDA while SCL is high. It ends with both lines released and exactly one stop condition.
- R5: Write (`cmd_op`=4) sends `cmd_wdata` MSB first on eight clocks, then releases SDA for a ninth clock. `rsp_acked`=1 exactly when SDA was low at the end of that ninth high phase.
- R6: Read (`cmd_op`=5) releases SDA, samples eight bits MSB first into `rsp_rdata`, and then drives a ninth clock. On that clock SDA is pulled low when `cmd_send_ack`=1 and released when it is 0.
- R7: With `cfg_scl_sense`=1, a high phase lasts U cycles counted from the first cycle the synchronised SCL reads high. That is U+2 cycles of release when nothing holds SCL. A stretch shorter than `cfg_stretch_max` only delays completion.
- R8: If SCL is still low after more than `cfg_stretch_max` cycles of waiting, the operation ends with `cmd_done` and `err_timeout`=1. The flag stays set while idle and is cleared when the next command is accepted.
- R9: With `cfg_scl_sense`=0, SCL is never checked. Each high phase lasts exactly U cycles and a held-low SCL raises no timeout.
- R10: `cfg_unit`=0 selects a default unit of 5 cycles with sensing on and 50 cycles with sensing off.
- R11: A command is accepted when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only when idle. `cmd_done` is a single-cycle pulse followed by `cmd_ready`. An unused code (0, 6 or 7) completes one cycle after acceptance with no line change.
- R12: SCL and SDA drives never change in the same cycle. SDA drive is constant throughout each data or acknowledge high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation: 1 start, 2 repeated start, 3 stop, 4 write, 5 read |
| cmd_wdata | input | 8 | Byte to write |
| cmd_send_ack | input | 1 | Read: 1 drives ACK on the ninth clock, 0 drives NAK |
| cfg_unit | input | 16 | Delay unit U in clock cycles; 0 selects the default |
| cfg_stretch_max | input | 20 | Maximum cycles to wait for SCL high |
| cfg_scl_sense | input | 1 | 1 enables SCL read-back and stretch handling |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| rsp_acked | output | 1 | Acknowledge seen on the last write |
| err_timeout | output | 1 | Sticky stretch timeout flag |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_in | input | 1 | Sensed SCL wire level |
| sda_in | input | 1 | Sensed SDA wire level |

## Verification
Line drives are registered, so each edge appears in the cycle its state is entered. The SDA-to-SCL gap of a start is therefore U cycles. A sensed high phase is U+2 cycles: two synchroniser stages plus U. A blind high phase is exactly U cycles. `cmd_done` rises one cycle after the last phase ends, and an unused code gives `cmd_done` in the first cycle after acceptance. The bench never waits a fixed time for completion. It polls `cmd_done` on falling edges and reads results in that cycle. It times line intervals from the cycle each drive changes, and decodes start, stop and data bits from the wire levels, so the checks hold however many stretch cycles pass in between.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_RESTART = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_ST_SDA,
        S_ST_SCL,
        S_RS_REL,
        S_RS_HIGH,
        S_RS_SDA,
        S_RS_SCL,
        S_SP_SDA,
        S_SP_HIGH,
        S_SP_REL,
        S_BIT_SET,
        S_BIT_HIGH,
        S_BIT_LOW,
        S_ACK_SET,
        S_ACK_HIGH,
        S_ACK_LOW,
        S_DONE
    } state_e;

endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
    parameter int               WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RESET_VAL;
            sync_out <= RESET_VAL;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end

endmodule

// File: rtl/i2c_cycle_counter.sv
module i2c_cycle_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] MAX_COUNT = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (enable && (count != MAX_COUNT)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_bit_pkg::*;
#(
    parameter int BYTE_W           = 8,
    parameter int UNIT_W           = 16,
    parameter int TMO_W            = 20,
    parameter int DEF_UNIT_SENSE   = 5,
    parameter int DEF_UNIT_NOSENSE = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic              cmd_send_ack,
    input  logic [UNIT_W-1:0] cfg_unit,
    input  logic [TMO_W-1:0]  cfg_stretch_max,
    input  logic              cfg_scl_sense,
    output logic              cmd_ready,
    output logic              cmd_done,
    output logic [BYTE_W-1:0] rsp_rdata,
    output logic              rsp_acked,
    output logic              err_timeout,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              scl_in,
    input  logic              sda_in
);

    localparam int               CNT_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [UNIT_W-1:0] DEF_ON  = UNIT_W'(DEF_UNIT_SENSE);
    localparam logic [UNIT_W-1:0] DEF_OFF = UNIT_W'(DEF_UNIT_NOSENSE);

    state_e            state_q, state_d;
    op_e               op_q;
    logic [BYTE_W-1:0] shift_q;
    logic              ack_pull_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              hi_ok_q;
    logic              scl_d, sda_d;

    // Synchronised pad returns: bit 0 = SCL, bit 1 = SDA
    logic [1:0] pad_sync;
    logic       scl_s, sda_s;

    i2c_sync2 #(
        .WIDTH    (2),
        .RESET_VAL(2'b11)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sda_in, scl_in}),
        .sync_out(pad_sync)
    );

    assign scl_s = pad_sync[0];
    assign sda_s = pad_sync[1];

    // Delay unit selection and derived phase lengths
    logic [UNIT_W-1:0] unit_eff;
    logic [UNIT_W:0]   unit_plus1;
    logic [UNIT_W-1:0] half_up, half_dn, tgt;

    always_comb begin
        if (cfg_unit != '0) begin
            unit_eff = cfg_unit;
        end else if (cfg_scl_sense) begin
            unit_eff = DEF_ON;
        end else begin
            unit_eff = DEF_OFF;
        end
        unit_plus1 = {1'b0, unit_eff} + {{UNIT_W{1'b0}}, 1'b1};
        half_up    = unit_plus1[UNIT_W:1];
        half_dn    = unit_eff >> 1;
    end

    always_comb begin
        case (state_q)
            S_ST_SDA, S_RS_HIGH, S_RS_SDA, S_SP_HIGH,
            S_SP_REL, S_BIT_HIGH, S_ACK_HIGH:            tgt = unit_eff;
            S_RS_REL, S_SP_SDA, S_BIT_SET, S_ACK_SET:    tgt = half_up;
            S_ST_SCL, S_RS_SCL, S_BIT_LOW, S_ACK_LOW:    tgt = half_dn;
            default:                                     tgt = '0;
        endcase
    end

    // High-phase qualification and stretch supervision
    logic is_high, hi_ok_c, stretch_wait, tmo_hit, stretch_fail;
    logic ph_last, high_end;
    logic [UNIT_W-1:0] ph_cnt;
    logic [UNIT_W:0]   ph_next;
    logic [TMO_W-1:0]  st_cnt;

    assign is_high      = (state_q == S_RS_HIGH) || (state_q == S_SP_HIGH) ||
                          (state_q == S_BIT_HIGH) || (state_q == S_ACK_HIGH);
    assign hi_ok_c      = hi_ok_q || scl_s || !cfg_scl_sense;
    assign stretch_wait = is_high && !hi_ok_c;
    assign tmo_hit      = (st_cnt >= cfg_stretch_max);
    assign stretch_fail = stretch_wait && tmo_hit;
    assign ph_next      = {1'b0, ph_cnt} + {{UNIT_W{1'b0}}, 1'b1};
    assign ph_last      = (ph_next >= {1'b0, tgt});
    assign high_end     = hi_ok_c && ph_last;

    i2c_cycle_counter #(
        .WIDTH(UNIT_W)
    ) u_phase_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear ((state_d != state_q) || stretch_wait),
        .enable(1'b1),
        .count (ph_cnt)
    );

    i2c_cycle_counter #(
        .WIDTH(TMO_W)
    ) u_stretch_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!stretch_wait),
        .enable(stretch_wait),
        .count (st_cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (op_e'(cmd_op))
                        OP_START:   state_d = S_ST_SDA;
                        OP_RESTART: state_d = S_RS_REL;
                        OP_STOP:    state_d = S_SP_SDA;
                        OP_WRITE,
                        OP_READ:    state_d = S_BIT_SET;
                        default:    state_d = S_DONE;
                    endcase
                end
            end
            S_ST_SDA:  if (ph_last) state_d = S_ST_SCL;
            S_ST_SCL:  if (ph_last) state_d = S_DONE;
            S_RS_REL:  if (ph_last) state_d = S_RS_HIGH;
            S_RS_HIGH: begin
                if (stretch_fail)  state_d = S_DONE;
                else if (high_end) state_d = S_RS_SDA;
            end
            S_RS_SDA:  if (ph_last) state_d = S_RS_SCL;
            S_RS_SCL:  if (ph_last) state_d = S_DONE;
            S_SP_SDA:  if (ph_last) state_d = S_SP_HIGH;
            S_SP_HIGH: begin
                if (stretch_fail)  state_d = S_DONE;
                else if (high_end) state_d = S_SP_REL;
            end
            S_SP_REL:  if (ph_last) state_d = S_DONE;
            S_BIT_SET: if (ph_last) state_d = S_BIT_HIGH;
            S_BIT_HIGH: begin
                if (stretch_fail)  state_d = S_DONE;
                else if (high_end) state_d = S_BIT_LOW;
            end
            S_BIT_LOW: begin
                if (ph_last) begin
                    state_d = (bit_cnt_q == LAST_BIT) ? S_ACK_SET : S_BIT_SET;
                end
            end
            S_ACK_SET: if (ph_last) state_d = S_ACK_HIGH;
            S_ACK_HIGH: begin
                if (stretch_fail)  state_d = S_DONE;
                else if (high_end) state_d = S_ACK_LOW;
            end
            S_ACK_LOW: if (ph_last) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Line drive: decided on entry to each state, held otherwise
    logic is_wr_op, next_bit;

    assign is_wr_op = (state_q == S_IDLE) ? (op_e'(cmd_op) == OP_WRITE) : (op_q == OP_WRITE);
    assign next_bit = (state_q == S_IDLE) ? cmd_wdata[BYTE_W-1] : shift_q[BYTE_W-1];

    always_comb begin
        scl_d = scl_pull;
        sda_d = sda_pull;
        if (state_d != state_q) begin
            case (state_d)
                S_ST_SDA, S_RS_SDA, S_SP_SDA:                  sda_d = 1'b1;
                S_RS_REL, S_SP_REL:                            sda_d = 1'b0;
                S_BIT_SET:                                     sda_d = is_wr_op ? !next_bit : 1'b0;
                S_ACK_SET:                                     sda_d = is_wr_op ? 1'b0 : ack_pull_q;
                S_RS_HIGH, S_SP_HIGH, S_BIT_HIGH, S_ACK_HIGH:  scl_d = 1'b0;
                S_ST_SCL, S_RS_SCL, S_BIT_LOW, S_ACK_LOW:      scl_d = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            scl_pull <= scl_d;
            sda_pull <= sda_d;
        end
    end

    // Datapath and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= OP_NONE;
            shift_q     <= '0;
            ack_pull_q  <= 1'b0;
            bit_cnt_q   <= '0;
            hi_ok_q     <= 1'b0;
            rsp_rdata   <= '0;
            rsp_acked   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                hi_ok_q <= 1'b0;
            end else if (is_high && hi_ok_c) begin
                hi_ok_q <= 1'b1;
            end
            if ((state_q == S_IDLE) && cmd_valid) begin
                op_q        <= op_e'(cmd_op);
                shift_q     <= cmd_wdata;
                ack_pull_q  <= cmd_send_ack;
                bit_cnt_q   <= '0;
                err_timeout <= 1'b0;
            end
            if ((state_q == S_BIT_HIGH) && high_end) begin
                shift_q <= {shift_q[BYTE_W-2:0], sda_s};
            end
            if ((state_q == S_BIT_LOW) && ph_last) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if ((state_q == S_ACK_HIGH) && high_end) begin
                if (op_q == OP_WRITE) begin
                    rsp_acked <= !sda_s;
                end else begin
                    rsp_rdata <= shift_q;
                end
            end
            if (stretch_fail) begin
                err_timeout <= 1'b1;
            end
        end
    end

    assign cmd_ready = (state_q == S_IDLE);
    assign cmd_done  = (state_q == S_DONE);

endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk
    import i2c_bit_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cmd_valid,
    input logic   cmd_ready,
    input logic   cmd_done,
    input logic   err_timeout,
    input logic   scl_pull,
    input logic   sda_pull,
    input state_e state_q
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);  // R11

    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> cmd_ready);  // R11

    AST_IDLE_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> ($stable(scl_pull) && $stable(sda_pull)));  // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout && !(cmd_valid && cmd_ready)) |=> err_timeout);  // R8

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !err_timeout);  // R8

    AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull != $past(scl_pull)) |-> (sda_pull == $past(sda_pull)));  // R12

    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == S_BIT_HIGH) || (state_q == S_ACK_HIGH)) && (state_q == $past(state_q)))
        |-> $stable(sda_pull));  // R12

endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_done   (cmd_done),
    .err_timeout(err_timeout),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .state_q    (state_q)
);

// File: tb/i2c_bit_engine_tb.sv
`timescale 1ns/1ps
module i2c_bit_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_wdata = 8'h00;
    logic        cmd_send_ack = 1'b0;
    logic [15:0] cfg_unit = 16'd8;
    logic [19:0] cfg_stretch_max = 20'd1000;
    logic        cfg_scl_sense = 1'b1;
    logic        cmd_ready, cmd_done, rsp_acked, err_timeout, scl_pull, sda_pull;
    logic [7:0]  rsp_rdata;

    logic        hold_scl = 1'b0;
    int          slv_mode = 0;      // 0 silent, 1 ack a write, 2 transmit a byte
    logic        slv_ack  = 1'b0;
    logic [7:0]  slv_tx   = 8'h00;

    // Monitor state
    int          falls = 0, n_start = 0, n_stop = 0, mon_bits = 0;
    logic [8:0]  mon_shift = '0;
    int          cyc = 0, t_sda = 0, t_scl = 0, rel_run = 0, min_run = 0, max_run = 0;
    logic        scl_p = 1'b1, sda_p = 1'b1, sclpd_p = 1'b0, sdapd_p = 1'b0;

    int          checks = 0, fails = 0, last_cycles = 0;
    bit          finished = 1'b0;

    function automatic logic slave_pull(int m, int f, logic a, logic [7:0] tx);
        if (m == 1) return a && (f == 8);
        if (m == 2 && f < 8) return !tx[7 - f];
        return 1'b0;
    endfunction

    wire scl_line = !(scl_pull || hold_scl);
    wire sda_line = !(sda_pull || slave_pull(slv_mode, falls, slv_ack, slv_tx));

    i2c_bit_engine u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_wdata      (cmd_wdata),
        .cmd_send_ack   (cmd_send_ack),
        .cfg_unit       (cfg_unit),
        .cfg_stretch_max(cfg_stretch_max),
        .cfg_scl_sense  (cfg_scl_sense),
        .cmd_ready      (cmd_ready),
        .cmd_done       (cmd_done),
        .rsp_rdata      (rsp_rdata),
        .rsp_acked      (rsp_acked),
        .err_timeout    (err_timeout),
        .scl_pull       (scl_pull),
        .sda_pull       (sda_pull),
        .scl_in         (scl_line),
        .sda_in         (sda_line)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (scl_p && scl_line && sda_p && !sda_line) n_start = n_start + 1;
        if (scl_p && scl_line && !sda_p && sda_line) n_stop = n_stop + 1;
        if (!scl_p && scl_line) begin
            mon_shift = {mon_shift[7:0], sda_line};
            mon_bits  = mon_bits + 1;
        end
        if (scl_p && !scl_line) falls = falls + 1;
        if (sda_pull && !sdapd_p) t_sda = cyc;
        if (scl_pull && !sclpd_p) t_scl = cyc;
        if (!scl_pull && !cmd_ready) rel_run = rel_run + 1;
        if (scl_pull && !sclpd_p && rel_run > 0) begin
            if (min_run == 0 || rel_run < min_run) min_run = rel_run;
            if (rel_run > max_run) max_run = rel_run;
        end
        if (scl_pull) rel_run = 0;
        scl_p = scl_line; sda_p = sda_line; sclpd_p = scl_pull; sdapd_p = sda_pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input logic ack);
        int n;
        @(negedge clk);
        falls = 0; n_start = 0; n_stop = 0; mon_bits = 0; mon_shift = '0;
        rel_run = 0; min_run = 0; max_run = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_send_ack = ack;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        while (!cmd_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        last_cycles = n;
        chk(cmd_done == 1'b1, "R11 done arrives", int'(cmd_done), 1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 lines released", {scl_pull, sda_pull}, 0);
        chk(cmd_ready == 1'b1 && err_timeout == 1'b0, "R1 ready/err", {cmd_ready, err_timeout}, 2);
    endtask

    task automatic t_start(input int unit, input string tag);
        run_cmd(3'd1, 8'h00, 1'b0);
        chk(n_start == 1, {tag, " start seen"}, n_start, 1);
        chk(t_scl - t_sda == unit, {tag, " SDA to SCL gap"}, t_scl - t_sda, unit);
        chk(scl_pull && sda_pull, {tag, " both pulled"}, {scl_pull, sda_pull}, 3);
    endtask

    task automatic t_write(input logic [7:0] b, input logic ack);
        slv_mode = 1; slv_ack = ack;
        run_cmd(3'd4, b, 1'b0);
        chk(mon_bits == 9 && mon_shift[8:1] == b, "R5 byte on bus", mon_shift[8:1], b);
        chk(mon_shift[0] == !ack && rsp_acked == ack, "R5 ack result", rsp_acked, ack);
        chk(min_run == 10 && max_run == 10, "R7 sensed high phase", min_run, 10);
        slv_mode = 0;
    endtask

    task automatic t_read(input logic [7:0] b, input logic ack);
        slv_mode = 2; slv_tx = b;
        run_cmd(3'd5, 8'h00, ack);
        chk(rsp_rdata == b, "R6 read byte", rsp_rdata, b);
        chk(mon_bits == 9 && mon_shift[0] == !ack, "R6 ninth clock", mon_shift[0], !ack);
        slv_mode = 0;
    endtask

    task automatic t_restart;
        run_cmd(3'd2, 8'h00, 1'b0);
        chk(n_start == 1, "R3 start seen", n_start, 1);
        chk(scl_pull && sda_pull, "R3 both pulled", {scl_pull, sda_pull}, 3);
    endtask

    task automatic t_stop(input string tag);
        run_cmd(3'd3, 8'h00, 1'b0);
        chk(n_stop == 1, {tag, " stop seen"}, n_stop, 1);
        chk(!scl_pull && !sda_pull, {tag, " both released"}, {scl_pull, sda_pull}, 0);
    endtask

    task automatic t_unused_code;
        logic s0, d0;
        s0 = scl_pull; d0 = sda_pull;
        run_cmd(3'd7, 8'h00, 1'b0);
        chk(last_cycles == 1, "R11 unused code latency", last_cycles, 1);
        chk(scl_pull == s0 && sda_pull == d0, "R11 unused code no line change", {scl_pull, sda_pull}, {s0, d0});
    endtask

    task automatic t_stretch;
        slv_mode = 1; slv_ack = 1'b1; hold_scl = 1'b1;
        fork
            begin
                repeat (40) @(negedge clk);
                hold_scl = 1'b0;
            end
        join_none
        run_cmd(3'd4, 8'h81, 1'b0);
        chk(err_timeout == 1'b0, "R7 short stretch no error", err_timeout, 0);
        chk(mon_shift[8:1] == 8'h81 && rsp_acked, "R7 byte after stretch", mon_shift[8:1], 8'h81);
        chk(last_cycles > 40, "R7 completion delayed", last_cycles, 41);
        slv_mode = 0;
    endtask

    task automatic t_timeout;
        cfg_stretch_max = 20'd30; hold_scl = 1'b1;
        run_cmd(3'd4, 8'h00, 1'b0);
        chk(err_timeout == 1'b1, "R8 timeout flagged", err_timeout, 1);
        chk(last_cycles >= 30, "R8 waited the limit", last_cycles, 30);
        repeat (20) @(negedge clk);
        chk(err_timeout == 1'b1, "R8 flag sticky", err_timeout, 1);
        hold_scl = 1'b0; cfg_stretch_max = 20'd1000;
        t_stop("R4");
        chk(err_timeout == 1'b0, "R8 cleared by next command", err_timeout, 0);
    endtask

    task automatic t_blind;
        cfg_scl_sense = 1'b0;
        t_start(8, "R2");
        run_cmd(3'd4, 8'h55, 1'b0);
        chk(min_run == 8 && max_run == 8, "R9 blind high phase", max_run, 8);
        chk(mon_shift[8:1] == 8'h55, "R9 blind byte", mon_shift[8:1], 8'h55);
        hold_scl = 1'b1;
        run_cmd(3'd4, 8'hF0, 1'b0);
        chk(err_timeout == 1'b0 && last_cycles < 2000, "R9 no timeout when held", err_timeout, 0);
        hold_scl = 1'b0;
        t_stop("R4");
        cfg_scl_sense = 1'b1;
    endtask

    task automatic t_default_unit;
        cfg_unit = 16'd0;
        t_start(5, "R10 sensed");
        t_stop("R4");
        cfg_scl_sense = 1'b0;
        t_start(50, "R10 blind");
        t_stop("R4");
        cfg_scl_sense = 1'b1; cfg_unit = 16'd8;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_start(8, "R2");
        t_write(8'hA5, 1'b1);
        t_write(8'h3C, 1'b0);
        t_restart();
        t_read(8'h96, 1'b1);
        t_read(8'h5A, 1'b0);
        t_stop("R4");
        t_unused_code();
        t_start(8, "R2");
        t_stretch();
        t_timeout();
        t_blind();
        t_default_unit();
        finish_run();
    end

endmodule